// File: doc/BRIEF.md
# Macro Processor Execute Unit

This block is the datapath of a small 32-bit macro processor. Each cycle it takes one decoded instruction. It reads two operands from an eight-entry register file and computes a 32-bit result in the same cycle. When the instruction commits, it writes that result back and updates a persistent carry/borrow flag. Entry 0 of the register file is a constant zero. The other seven entries are real 32-bit storage.

The unit supports six operation classes:
- a register ALU with carry- and borrow-chained add and subtract, plus bitwise logic;
- add of a sign-extended 18-bit immediate;
- a bitfield merge, which inserts a field of one operand into the other;
- two forms of bitfield extract-and-shift, with the positions taken from instruction fields or from a register;
- state-read address generation.

Instruction fetch, parameter input and emission of results sit around this unit and are not part of it.

Top module: `mpx_exec_unit`

## Requirements
- R1: Register index 0 always reads as 0, and a write to index 0 has no effect.
- R2: Indices 1 to 7 are 32-bit registers, cleared by reset. The register at `dst_i` takes `result_o` at the clock edge where `commit_i` and `wr_en_i` are both 1, and keeps its value otherwise.
- R3: `imm_i` is sign-extended from 18 to 32 bits. Op class 1 (add-immediate) gives x + imm.
- R4: Op class 0 with `alu_fn_i` 0 gives x + y, and with `alu_fn_i` 1 gives x + y + carry. Both set the carry to (result < x), compared unsigned.
- R5: `alu_fn_i` 2 gives x − y, and `alu_fn_i` 3 gives x − y − carry. Both set the carry to (result > x), compared unsigned.
- R6: `alu_fn_i` 4 to 8 give XOR, OR, AND, x & ~y and ~(x & y), and leave the carry unchanged. Function codes 9 to 15 give 0 and also leave the carry unchanged.
- R7: Op class 2 (merge) returns x, with the `fld_size_i`-bit field at bit `fld_dst_i` replaced by the field of y of the same size starting at bit `fld_src_i`.
- R8: Op class 3 returns ((y >> x) & mask(size)) << `fld_dst_i`, and returns 0 when x > 31.
- R9: Op class 4 returns ((y >> `fld_src_i`) & mask(size)) << x, and returns 0 when x > 31.
- R10: A size of 0 gives an empty mask. Extract then returns 0, and merge returns x unchanged.
- R11: Op class 5 returns (x + sign-extended imm) * 4. Op classes 6 and 7 return 0.
- R12: The carry is 0 after reset and changes only at a clock edge where `commit_i` is 1 with op class 0 and `alu_fn_i` 0 to 3.

In all requirements, x is the register at `src_a_i` and y is the register at `src_b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_i | input | 1 | The instruction commits at this edge |
| op_i | input | 3 | Operation class |
| alu_fn_i | input | 4 | Register-ALU function |
| src_a_i | input | 3 | Index of operand x |
| src_b_i | input | 3 | Index of operand y |
| dst_i | input | 3 | Destination index |
| wr_en_i | input | 1 | Write the result to the destination on commit |
| imm_i | input | 18 | Signed immediate |
| fld_src_i | input | 5 | Bitfield source bit |
| fld_dst_i | input | 5 | Bitfield destination bit |
| fld_size_i | input | 5 | Bitfield width |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Carry/borrow flag |

## Verification
The bench goes after carry chaining across back-to-back arithmetic. A design that computes the flag as a true 33-bit carry would report a wrong flag for add-with-carry of 0xFFFFFFFF plus a carry-in. It also checks that logic operations and uncommitted instructions leave the flag alone; a design that updated it on every cycle would lose a pending borrow.

On the bitfield side, the bench drives shift positions of exactly 31 and 32 and a size of 0. A design that masked the position to 5 bits, or built the mask as 2^size − 1 with a wrapped size, would produce nonzero fields where 0 is required.

Negative immediates in the add-immediate and state-address classes expose a missing sign extension. Writes to index 0 expose a register 0 that can be written.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  typedef enum logic [2:0] {
    OPC_ALU   = 3'd0,
    OPC_ADDI  = 3'd1,
    OPC_MERGE = 3'd2,
    OPC_XSH_I = 3'd3,
    OPC_XSH_R = 3'd4,
    OPC_SADDR = 3'd5
  } opc_e;

  typedef enum logic [3:0] {
    FN_ADD  = 4'd0,
    FN_ADDC = 4'd1,
    FN_SUB  = 4'd2,
    FN_SUBB = 4'd3,
    FN_XOR  = 4'd4,
    FN_OR   = 4'd5,
    FN_AND  = 4'd6,
    FN_ANDN = 4'd7,
    FN_NAND = 4'd8
  } alu_fn_e;
endpackage

// File: rtl/mpx_regfile.sv
module mpx_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] store [1:NREG-1];

  // Entry 0 has no storage; only entries 1..NREG-1 exist.
  for (genvar g = 1; g < NREG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        store[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))
        store[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int k = 1; k < NREG; k++) begin
      if (rd_a_idx == IW'(k)) rd_a = store[k];
      if (rd_b_idx == IW'(k)) rd_b = store[k];
    end
  end
endmodule

// File: rtl/mpx_alu.sv
module mpx_alu
  import mpx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [3:0]    fn,
  input  logic          carry_in,
  output logic [DW-1:0] res,
  output logic          carry_out,
  output logic          carry_upd
);
  function automatic logic [DW-1:0] add3(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                         input logic c);
    return a + b + {{(DW-1){1'b0}}, c};
  endfunction

  function automatic logic [DW-1:0] sub3(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                         input logic c);
    return a - b - {{(DW-1){1'b0}}, c};
  endfunction

  always_comb begin
    res       = '0;
    carry_out = carry_in;
    carry_upd = 1'b0;
    unique case (alu_fn_e'(fn))
      FN_ADD:  begin res = add3(x, y, 1'b0);     carry_out = res < x; carry_upd = 1'b1; end
      FN_ADDC: begin res = add3(x, y, carry_in); carry_out = res < x; carry_upd = 1'b1; end
      FN_SUB:  begin res = sub3(x, y, 1'b0);     carry_out = res > x; carry_upd = 1'b1; end
      FN_SUBB: begin res = sub3(x, y, carry_in); carry_out = res > x; carry_upd = 1'b1; end
      FN_XOR:  res = x ^ y;
      FN_OR:   res = x | y;
      FN_AND:  res = x & y;
      FN_ANDN: res = x & ~y;
      FN_NAND: res = ~(x & y);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/mpx_bitfield.sv
module mpx_bitfield
  import mpx_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 5
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [FW-1:0] fsrc,
  input  logic [FW-1:0] fdst,
  input  logic [FW-1:0] fsize,
  output logic [DW-1:0] res
);
  function automatic logic [DW-1:0] fmask(input logic [FW-1:0] n);
    return (DW'(1) << n) - DW'(1);
  endfunction

  function automatic logic [DW-1:0] xshift(input logic [DW-1:0] v, input logic [DW-1:0] s,
                                           input logic [DW-1:0] d, input logic [FW-1:0] n);
    if (s > DW'(DW-1) || d > DW'(DW-1)) return '0;
    return ((v >> s) & fmask(n)) << d;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] base, input logic [DW-1:0] v,
                                          input logic [FW-1:0] s, input logic [FW-1:0] d,
                                          input logic [FW-1:0] n);
    return (base & ~(fmask(n) << d)) | (((v >> s) & fmask(n)) << d);
  endfunction

  always_comb begin
    unique case (opc_e'(op))
      OPC_MERGE: res = merge(x, y, fsrc, fdst, fsize);
      OPC_XSH_I: res = xshift(y, x, DW'(fdst), fsize);
      OPC_XSH_R: res = xshift(y, DW'(fsrc), x, fsize);
      default:   res = '0;
    endcase
  end
endmodule

// File: rtl/mpx_exec_unit.sv
module mpx_exec_unit
  import mpx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int IMW  = 18,
  parameter int FW   = 5,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic [2:0]    op_i,
  input  logic [3:0]    alu_fn_i,
  input  logic [IW-1:0] src_a_i,
  input  logic [IW-1:0] src_b_i,
  input  logic [IW-1:0] dst_i,
  input  logic          wr_en_i,
  input  logic [IMW-1:0] imm_i,
  input  logic [FW-1:0] fld_src_i,
  input  logic [FW-1:0] fld_dst_i,
  input  logic [FW-1:0] fld_size_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  logic [DW-1:0] opnd_x, opnd_y, imm_sx, alu_res, bf_res;
  logic          alu_cout, alu_cupd, carry_we, reg_we, carry_q;

  function automatic logic [DW-1:0] sext(input logic [IMW-1:0] v);
    return {{(DW-IMW){v[IMW-1]}}, v};
  endfunction

  assign imm_sx = sext(imm_i);

  mpx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(src_a_i), .rd_b_idx(src_b_i),
    .rd_a(opnd_x), .rd_b(opnd_y),
    .wr_en(reg_we), .wr_idx(dst_i), .wr_data(result_o)
  );

  mpx_alu #(.DW(DW)) u_alu (
    .x(opnd_x), .y(opnd_y), .fn(alu_fn_i), .carry_in(carry_q),
    .res(alu_res), .carry_out(alu_cout), .carry_upd(alu_cupd)
  );

  mpx_bitfield #(.DW(DW), .FW(FW)) u_bf (
    .op(op_i), .x(opnd_x), .y(opnd_y),
    .fsrc(fld_src_i), .fdst(fld_dst_i), .fsize(fld_size_i), .res(bf_res)
  );

  always_comb begin
    unique case (opc_e'(op_i))
      OPC_ALU:   result_o = alu_res;
      OPC_ADDI:  result_o = opnd_x + imm_sx;
      OPC_MERGE, OPC_XSH_I, OPC_XSH_R: result_o = bf_res;
      OPC_SADDR: result_o = (opnd_x + imm_sx) << 2;
      default:   result_o = '0;
    endcase
  end

  assign reg_we   = commit_i && wr_en_i;
  assign carry_we = commit_i && (opc_e'(op_i) == OPC_ALU) && alu_cupd;

  always_ff @(posedge clk) begin
    if (!rst_n)        carry_q <= 1'b0;
    else if (carry_we) carry_q <= alu_cout;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/mpx_exec_unit_chk.sv
module mpx_exec_unit_chk #(
  parameter int DW = 32,
  parameter int IW = 3,
  parameter int FW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          commit_i,
  input logic [2:0]    op_i,
  input logic [3:0]    alu_fn_i,
  input logic [IW-1:0] src_a_i,
  input logic [FW-1:0] fld_size_i,
  input logic [DW-1:0] opnd_x,
  input logic [DW-1:0] result_o,
  input logic          carry_o
);
  assert_zero_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_i == '0) |-> (opnd_x == '0));

  assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && op_i == 3'd0 && alu_fn_i >= 4'd4) |=> $stable(carry_o));

  assert_xsh_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && opnd_x > DW'(DW-1)) |-> (result_o == '0));

  assert_merge_size0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && fld_size_i == '0) |-> (result_o == opnd_x));

  assert_saddr_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd5) |-> (result_o[1:0] == 2'b00));

  assert_idle_keeps_carry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_i) |=> $stable(carry_o));
endmodule

bind mpx_exec_unit mpx_exec_unit_chk #(.DW(DW), .IW(IW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .op_i(op_i), .alu_fn_i(alu_fn_i),
  .src_a_i(src_a_i), .fld_size_i(fld_size_i), .opnd_x(opnd_x),
  .result_o(result_o), .carry_o(carry_o)
);

// File: tb/mpx_exec_unit_tb.sv
module mpx_exec_unit_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic commit_i = 0, wr_en_i = 0;
  logic [2:0] op_i = 0, src_a_i = 0, src_b_i = 0, dst_i = 0;
  logic [3:0] alu_fn_i = 0;
  logic [17:0] imm_i = 0;
  logic [4:0] fld_src_i = 0, fld_dst_i = 0, fld_size_i = 0;
  logic [31:0] result_o;
  logic carry_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] mreg [8];
  bit mcarry;

  always #(CLK_P/2) clk = ~clk;

  mpx_exec_unit u_dut (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference for one instruction.
  task automatic ref_eval(output logic [31:0] r, output bit cw, output bit cn);
    logic [31:0] x, y, sx, m;
    x = mreg[src_a_i]; y = mreg[src_b_i];
    sx = 32'($signed(imm_i));
    m = (fld_size_i == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - int'(fld_size_i)));
    cw = 0; cn = mcarry; r = 0;
    case (op_i)
      0: case (alu_fn_i)
           0: begin r = x + y;          cw = 1; cn = (r < x); end
           1: begin r = x + y + mcarry; cw = 1; cn = (r < x); end
           2: begin r = x - y;          cw = 1; cn = (r > x); end
           3: begin r = x - y - mcarry; cw = 1; cn = (r > x); end
           4: r = x ^ y;
           5: r = x | y;
           6: r = x & y;
           7: r = x & ~y;
           8: r = ~(x & y);
           default: r = 0;
         endcase
      1: r = x + sx;
      2: r = (x & ~(m << fld_dst_i)) | (((y >> fld_src_i) & m) << fld_dst_i);
      3: r = (x > 31) ? 0 : (((y >> x) & m) << fld_dst_i);
      4: r = (x > 31) ? 0 : (((y >> fld_src_i) & m) << x);
      5: r = (x + sx) * 4;
      default: r = 0;
    endcase
  endtask

  task automatic exec(input int op, input int fn, input int a, input int b, input int d,
                      input bit we, input bit cm, input logic [17:0] imm,
                      input int fs, input int fd, input int fz, input string tag);
    logic [31:0] exp;
    bit cw, cn;
    @(negedge clk);
    op_i = 3'(op); alu_fn_i = 4'(fn); src_a_i = 3'(a); src_b_i = 3'(b); dst_i = 3'(d);
    wr_en_i = we; commit_i = cm; imm_i = imm;
    fld_src_i = 5'(fs); fld_dst_i = 5'(fd); fld_size_i = 5'(fz);
    #1;
    ref_eval(exp, cw, cn);
    check(result_o, exp, tag);
    check({31'b0, carry_o}, {31'b0, mcarry}, "R12");
    @(posedge clk);
    if (cm) begin
      if (we && d != 0) mreg[d] = exp;
      if (cw && op == 0) mcarry = cn;
    end
  endtask

  task automatic ld(input int d, input logic [17:0] imm);
    exec(1, 0, 0, 0, d, 1, 1, imm, 0, 0, 0, "R3");
  endtask

  task automatic alu(input int fn, input int a, input int b, input int d, input string tag);
    exec(0, fn, a, b, d, 1, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    exec(0, 5, a, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    foreach (mreg[i]) mreg[i] = 0;
    mcarry = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // Reset state: registers zero, carry clear
    for (int i = 1; i < 8; i++) rd(i, "R2");
    // Immediates, including negative ones
    ld(1, 18'h3FFFF); ld(2, 18'h00001); ld(3, 18'h1FFFF); ld(4, 18'h20000); ld(7, 18'd31);
    // Register zero ignores writes
    ld(0, 18'h00005); rd(0, "R1");
    // Add chain
    alu(0, 1, 2, 5, "R4"); alu(1, 2, 2, 6, "R4");
    alu(0, 1, 2, 5, "R4"); alu(1, 2, 1, 6, "R4"); alu(1, 1, 1, 6, "R4");
    // Subtract chain
    alu(2, 0, 2, 5, "R5"); alu(3, 3, 2, 6, "R5"); alu(3, 3, 2, 6, "R5");
    alu(2, 2, 2, 5, "R5"); alu(2, 0, 2, 5, "R5");
    // Logic ops keep the set carry
    for (int f = 4; f <= 9; f++) begin
      alu(f, 4, 3, 6, "R6");
      check({31'b0, carry_o}, 32'd1, "R6");
    end
    // Uncommitted overflow: carry and destination unchanged
    exec(0, 2, 2, 2, 6, 1, 0, 0, 0, 0, 0, "R12");
    check({31'b0, carry_o}, 32'd1, "R12");
    rd(6, "R2");
    exec(0, 0, 1, 1, 3, 0, 1, 0, 0, 0, 0, "R4");
    rd(3, "R2");
    // Merge
    exec(2, 0, 4, 3, 5, 1, 1, 0, 4, 8, 6, "R7");
    exec(2, 0, 1, 0, 5, 1, 1, 0, 0, 31, 1, "R7");
    exec(2, 0, 4, 1, 5, 1, 1, 0, 3, 9, 0, "R10");
    // Extract, immediate form (position from register)
    exec(3, 0, 2, 3, 5, 1, 1, 0, 0, 3, 5, "R8");
    exec(3, 0, 7, 1, 5, 1, 1, 0, 0, 4, 3, "R8");
    ld(6, 18'd32);
    exec(3, 0, 6, 1, 5, 1, 1, 0, 0, 0, 8, "R8");
    exec(3, 0, 1, 1, 5, 1, 1, 0, 0, 0, 8, "R8");
    exec(3, 0, 2, 1, 5, 1, 1, 0, 0, 2, 0, "R10");
    // Extract, register form
    exec(4, 0, 7, 1, 5, 1, 1, 0, 0, 0, 1, "R9");
    exec(4, 0, 2, 4, 5, 1, 1, 0, 17, 0, 12, "R9");
    exec(4, 0, 6, 1, 5, 1, 1, 0, 0, 0, 4, "R9");
    exec(4, 0, 0, 1, 5, 1, 1, 0, 3, 0, 0, "R10");
    // State address
    exec(5, 0, 3, 0, 5, 1, 1, 18'h3FFFD, 0, 0, 0, "R11");
    exec(5, 0, 0, 0, 5, 1, 1, 18'h20000, 0, 0, 0, "R11");
    exec(6, 0, 1, 1, 5, 1, 1, 0, 0, 0, 0, "R11");
    // Mixed stream
    for (int k = 0; k < 400; k++)
      exec(int'($urandom_range(0, 7)), int'($urandom_range(0, 10)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)), 1'($urandom),
           ($urandom_range(0, 3) != 0), 18'($urandom), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), "R2 mixed");
    for (int i = 0; i < 8; i++) rd(i, "R2");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule